// File: doc/BRIEF.md
# TDM8 Slave Serial Audio Receiver

This block receives an eight-slot time-division-multiplexed audio stream while acting as a clock slave. It runs directly on the incoming bit clock. It watches the frame clock for the edge that opens a frame, shifts in eight 32-bit slot words MSB first from the serial data line, and presents all eight words at once on a parallel bus together with a one-cycle frame-valid strobe.

The receiver locks only on the frame-opening transition and ignores the opposite transition. A short one-slot frame pulse and a half-frame square wave are therefore both accepted with no mode setting. A polarity input chooses whether the rising or the falling transition opens a frame. With a square-wave frame clock, this choice exchanges the first four slots with the last four. A second input chooses whether the first data bit follows the frame edge by one bit clock (the usual setting) or arrives together with it.

If the frame-opening edge does not come back exactly 256 bit clocks after the previous one, a misalignment strobe is raised. The incomplete frame is never presented, and the receiver locks again on the next frame-opening edge. The serial line cannot be stalled, so the output has a valid strobe but no ready. A word set stays on `slot_data` until the next complete frame replaces it.

Top module: `tdm8_slave_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `slot_data` is all zeros and `frame_valid` and `frame_misalign` are low until a frame completes or a fault is seen.
- R2: `fclk` and `sdin` are sampled on rising `bclk` edges. Each slot has 32 bits, MSB first. The k-th slot received in a frame (k = 0..7) appears on `slot_data[32k+31:32k]`.
- R3: With `cfg_fs_invert` = 0, a frame opens when a sample of `fclk` is 1 and the previous sample was 0. With `cfg_fs_invert` = 1, a frame opens on a sample of 0 that follows a 1.
- R4: With `cfg_zero_delay` = 0, bit 0 of slot 0 is the `sdin` sample taken one `bclk` after the sample that shows the frame edge. With `cfg_zero_delay` = 1, bit 0 is taken at the same sample as the edge.
- R5: A transition of `fclk` in the non-opening direction has no effect. A pulse one slot long and a square wave active for slots 0–3 both deliver the same words.
- R6: With a square-wave `fclk` and the polarity set opposite to the wave's first-half level, frames open at the mid-frame transition, so `slot_data` carries the last four slots of one frame followed by the first four of the next.
- R7: All 32·8 bits of `slot_data` change together, only in the cycle after the last bit of slot 7 is sampled. `frame_valid` is high for exactly that one cycle.
- R8: A frame-opening edge that arrives while locked and before 256 bits of the current frame have been taken raises `frame_misalign` for one cycle. The partial frame is never presented, and a new frame starts at that edge.
- R9: If no frame-opening edge is seen where bit 256 would begin, `frame_misalign` pulses for one cycle. No further `frame_valid` occurs until a new frame-opening edge starts a full frame.
- R10: The first frame-opening edge after reset, or after a loss of lock, is accepted without a misalignment strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fclk | input | 1 | Frame clock (pulse or square wave) |
| sdin | input | 1 | Serial audio data |
| cfg_fs_invert | input | 1 | 0: rising `fclk` opens a frame, 1: falling |
| cfg_zero_delay | input | 1 | 0: data one bit after the edge, 1: data on the edge |
| slot_data | output | 256 | Eight slot words, slot k at bits 32k+31:32k |
| frame_valid | output | 1 | One-cycle strobe when `slot_data` is updated |
| frame_misalign | output | 1 | One-cycle strobe on an early or missing frame edge |

## Verification
A wrong bit position inside the receiver shows up at the next `frame_valid`, at most 256 cycles later: words rotated between slots, bits shifted inside a word, or a strobe at the wrong spacing. A wrong lock state shows up either as a `frame_misalign` pulse where the frame clock was regular, or as a missing pulse in the cycle after an early or missing edge. Another sign is a `frame_valid` that carries a truncated frame. The bench drives every combination of frame-clock style, polarity and data delay, plus deliberately wrong polarities, an early edge and a missing edge. It predicts each word from the stream arithmetic.

// File: rtl/tdm8_rx_pkg.sv
package tdm8_rx_pkg;
  localparam int unsigned DEF_SLOT_BITS = 32;
  localparam int unsigned DEF_SLOTS     = 8;

  // Which fclk transition opens a frame
  typedef enum logic {
    FS_RISE_OPENS = 1'b0,
    FS_FALL_OPENS = 1'b1
  } fs_edge_e;
endpackage

// File: rtl/tdm8_rx_edge.sv
// Frame-edge detector: finds the opening transition of fclk and aligns the
// start event with the first data bit according to the delay setting.
module tdm8_rx_edge
  import tdm8_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fclk,
  input  logic invert,
  input  logic zero_delay,
  output logic start
);
  fs_edge_e sel;
  logic     open_level;
  logic     fs_q;
  logic     prime_q;
  logic     edge_now;
  logic     edge_q;

  assign sel        = fs_edge_e'(invert);
  assign open_level = (sel == FS_RISE_OPENS);
  // Only a change toward the opening level counts; the other direction is dropped
  assign edge_now   = prime_q && (fclk != fs_q) && (fclk == open_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      prime_q <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      fs_q    <= fclk;
      prime_q <= 1'b1;
      edge_q  <= edge_now;
    end
  end

  // Delaying the start event, not the data, gives the one-bit offset
  assign start = zero_delay ? edge_now : edge_q;
endmodule

// File: rtl/tdm8_rx_framer.sv
// Frame position tracker: bit index within the frame, lock state and
// misalignment detection.
module tdm8_rx_framer #(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             capture,
  output logic [POS_W-1:0] idx,
  output logic             misalign
);
  logic [POS_W-1:0] pos_q;
  logic             synced_q;
  logic             early;
  logic             missed;

  // pos_q is the index of the bit expected this cycle; 0 while locked means
  // a full frame has been taken and the next opening edge is due now
  assign early    = start && synced_q && (pos_q != '0);
  assign missed   = !start && synced_q && (pos_q == '0);
  assign capture  = start || (synced_q && (pos_q != '0));
  assign idx      = start ? '0 : pos_q;
  assign misalign = early || missed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      if (capture) begin
        pos_q    <= idx + POS_W'(1);
        synced_q <= 1'b1;
      end else if (missed) begin
        synced_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm8_rx_slots.sv
// Slot assembler: one shared shifter, a holding word for every slot but the
// last, and the parallel output registers.
module tdm8_rx_slots #(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned SLOTS     = 8,
  localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned POS_W    = BIT_W + SLOT_W,
  localparam int unsigned BUS_W    = SLOT_BITS * SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [POS_W-1:0] idx,
  input  logic             sdin,
  input  logic             misalign,
  output logic [BUS_W-1:0] slot_data,
  output logic             frame_valid,
  output logic             frame_misalign
);
  logic [SLOT_BITS-1:0] shreg_q;
  logic [SLOT_BITS-1:0] word_now;
  logic [SLOT_W-1:0]    slot_id;
  logic                 slot_end;
  logic                 frame_end;
  logic [BUS_W-1:0]     frame_word;
  logic [BUS_W-1:0]     data_q;
  logic                 valid_q;
  logic                 mis_q;

  assign word_now  = {shreg_q[SLOT_BITS-2:0], sdin};
  assign slot_id   = idx[BIT_W +: SLOT_W];
  assign slot_end  = capture && (idx[BIT_W-1:0] == BIT_W'(SLOT_BITS - 1));
  assign frame_end = slot_end && (slot_id == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else if (capture) shreg_q <= word_now;
  end

  for (genvar g = 0; g < SLOTS - 1; g++) begin : g_hold
    logic [SLOT_BITS-1:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= '0;
      else if (slot_end && (slot_id == SLOT_W'(g))) held_q <= word_now;
    end
    assign frame_word[g*SLOT_BITS +: SLOT_BITS] = held_q;
  end
  // The last slot goes straight from the shifter to the output
  assign frame_word[(SLOTS-1)*SLOT_BITS +: SLOT_BITS] = word_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      if (frame_end) data_q <= frame_word;
      valid_q <= frame_end;
      mis_q   <= misalign;
    end
  end

  assign slot_data      = data_q;
  assign frame_valid    = valid_q;
  assign frame_misalign = mis_q;
endmodule

// File: rtl/tdm8_slave_rx.sv
module tdm8_slave_rx
  import tdm8_rx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned SLOTS     = DEF_SLOTS,
  localparam int unsigned FRAME_BITS = SLOT_BITS * SLOTS,
  localparam int unsigned POS_W      = $clog2(FRAME_BITS)
) (
  input  logic                  bclk,
  input  logic                  rst_n,
  input  logic                  fclk,
  input  logic                  sdin,
  input  logic                  cfg_fs_invert,
  input  logic                  cfg_zero_delay,
  output logic [FRAME_BITS-1:0] slot_data,
  output logic                  frame_valid,
  output logic                  frame_misalign
);
  logic             start;
  logic             capture;
  logic [POS_W-1:0] idx;
  logic             misalign;

  tdm8_rx_edge u_edge (
    .clk        (bclk),
    .rst_n      (rst_n),
    .fclk       (fclk),
    .invert     (cfg_fs_invert),
    .zero_delay (cfg_zero_delay),
    .start      (start)
  );

  tdm8_rx_framer #(.FRAME_BITS(FRAME_BITS)) u_framer (
    .clk      (bclk),
    .rst_n    (rst_n),
    .start    (start),
    .capture  (capture),
    .idx      (idx),
    .misalign (misalign)
  );

  tdm8_rx_slots #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_slots (
    .clk            (bclk),
    .rst_n          (rst_n),
    .capture        (capture),
    .idx            (idx),
    .sdin           (sdin),
    .misalign       (misalign),
    .slot_data      (slot_data),
    .frame_valid    (frame_valid),
    .frame_misalign (frame_misalign)
  );
endmodule

// File: rtl/tdm8_slave_rx_chk.sv
module tdm8_slave_rx_chk #(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned SLOTS     = 8,
  localparam int unsigned FRAME_BITS = SLOT_BITS * SLOTS,
  localparam int unsigned GAP_W      = $clog2(FRAME_BITS) + 1
) (
  input logic                  bclk,
  input logic                  rst_n,
  input logic [FRAME_BITS-1:0] slot_data,
  input logic                  frame_valid,
  input logic                  frame_misalign
);
  // Cycles since the last frame_valid (or reset), saturating
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (frame_valid) gap_q <= '0;
    else if (gap_q != GAP_W'(FRAME_BITS)) gap_q <= gap_q + GAP_W'(1);
  end

  AST_RESET_CLEAR: assert property (@(posedge bclk)
    !rst_n |-> (slot_data == '0 && !frame_valid && !frame_misalign)); // R1

  AST_VALID_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R7

  AST_DATA_ONLY_ON_VALID: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(slot_data) |-> frame_valid); // R7

  AST_FULL_FRAME_SPACING: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_valid |-> (gap_q >= GAP_W'(FRAME_BITS - 1))); // R8

  AST_MISALIGN_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_misalign |=> !frame_misalign); // R9

  AST_NO_VALID_ON_MISALIGN: assert property (@(posedge bclk) disable iff (!rst_n)
    !(frame_valid && frame_misalign)); // R8
endmodule

bind tdm8_slave_rx tdm8_slave_rx_chk #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_chk (
  .bclk           (bclk),
  .rst_n          (rst_n),
  .slot_data      (slot_data),
  .frame_valid    (frame_valid),
  .frame_misalign (frame_misalign)
);

// File: tb/test_tdm8_slave_rx.sv
`timescale 1ns/1ps
module test_tdm8_slave_rx;
  logic         bclk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fclk = 1'b0;
  logic         sdin = 1'b0;
  logic         cfg_fs_invert = 1'b0;
  logic         cfg_zero_delay = 1'b0;
  logic [255:0] slot_data;
  logic         frame_valid;
  logic         frame_misalign;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expectation state used by the monitor
  int          g_n = 0;      // frames in current stream
  int          g_off = 0;    // bit offset of receiver frames into the stream
  logic [31:0] g_seed = '0;
  int          exp_k = 0;    // next receiver frame index
  int          vcnt = 0;
  int          mcnt = 0;
  bit          mon_en = 0;
  string       g_req = "R2";

  always #2.5 bclk = ~bclk;

  tdm8_slave_rx i_tdm8_slave_rx (
    .bclk           (bclk),
    .rst_n          (rst_n),
    .fclk           (fclk),
    .sdin           (sdin),
    .cfg_fs_invert  (cfg_fs_invert),
    .cfg_zero_delay (cfg_zero_delay),
    .slot_data      (slot_data),
    .frame_valid    (frame_valid),
    .frame_misalign (frame_misalign)
  );

  function automatic logic [31:0] gen(int f, int s);
    return (32'(f) * 32'h0100_0193) ^ (32'(s) * 32'h9E37_79B9) ^ g_seed;
  endfunction

  // Word expected in receiver slot s of receiver frame k
  function automatic logic [31:0] exp_word(int k, int s);
    int b = g_off + 256 * k + 32 * s;
    if (b / 256 >= g_n) return 32'h0;
    return gen(b / 256, (b % 256) / 32);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge bclk) begin
    if (mon_en && rst_n) begin
      if (frame_valid) begin
        logic [255:0] e;
        for (int s = 0; s < 8; s++) e[32*s +: 32] = exp_word(exp_k, s);
        chk(slot_data == e, g_req, $sformatf("frame %0d words", exp_k), slot_data, e);
        exp_k++;
        vcnt++;
      end
      if (frame_misalign) mcnt++;
    end
  end

  task automatic do_reset(bit inv, bit zd, logic idle_lvl);
    @(negedge bclk);
    rst_n = 1'b0;
    cfg_fs_invert = inv;
    cfg_zero_delay = zd;
    fclk = idle_lvl;
    sdin = 1'b0;
    repeat (4) @(negedge bclk);
    rst_n = 1'b1;
  endtask

  // Drives one stream: optional truncated prologue, n frames, then idle.
  // style: 0 = one-slot pulse, 1 = half-frame square wave. pol: 1 = active-low.
  task automatic run_stream(bit style, bit pol, bit zd, int n, int pre_len, int off, logic [31:0] seed);
    logic act = ~pol;
    int   dly = zd ? 0 : 1;
    int   len = style ? 128 : 32;
    g_n = n; g_off = off; g_seed = seed; exp_k = 0;
    for (int c = -pre_len; c < n * 256 + 300; c++) begin
      int d = c - dly;
      @(negedge bclk);
      if (c < 0) fclk = ((c + pre_len) < 8) ? act : ~act;
      else if (c < n * 256) fclk = ((c % 256) < len) ? act : ~act;
      else fclk = ~act;
      if (d < 0) sdin = c[0];
      else if (d >= n * 256) sdin = 1'b0;
      else sdin = gen(d / 256, (d % 256) / 32)[31 - (d % 32)];
    end
  endtask

  task automatic scenario(string req, bit style, bit pol, bit inv, bit zd, int n, int pre_len,
                          int off, int exp_v, int exp_m, logic [31:0] seed);
    do_reset(inv, zd, pol);
    g_req = req;
    vcnt = 0; mcnt = 0; mon_en = 1;
    run_stream(style, pol, zd, n, pre_len, off, seed);
    chk(vcnt == exp_v, req, "frame_valid count", 256'(vcnt), 256'(exp_v));
    chk(mcnt == exp_m, req, "frame_misalign count", 256'(mcnt), 256'(exp_m));
    mon_en = 0;
  endtask

  initial begin
    #(100000 * 5);
    $display("FAIL watchdog: actual timeout expected completion");
    errors++;
    checks++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, checked during and after reset
    do_reset(1'b0, 1'b0, 1'b0);
    @(negedge bclk);
    chk(slot_data == '0, "R1", "slot_data after reset", slot_data, '0);
    chk(!frame_valid && !frame_misalign, "R1", "strobes after reset",
        256'({frame_valid, frame_misalign}), '0);

    // R2 R3 R4 R5 R7 R9 R10: sweep of style x polarity x delay, matching polarity
    for (int st = 0; st < 2; st++)
      for (int p = 0; p < 2; p++)
        for (int z = 0; z < 2; z++)
          scenario("R4", st[0], p[0], p[0], z[0], 3, 0, 0, 3, 1,
                   32'hA5C3_0000 + 32'(st * 4 + p * 2 + z));

    // R6: square wave with opposite polarity opens frames mid-frame -> halves exchanged
    for (int p = 0; p < 2; p++)
      for (int z = 0; z < 2; z++)
        scenario("R6", 1'b1, p[0], ~p[0], z[0], 3, 0, 128, 3, 1, 32'h5EED_0100 + 32'(p * 2 + z));

    // R3: active-low pulse with non-inverted setting opens on the pulse's trailing edge
    scenario("R3", 1'b0, 1'b1, 1'b0, 1'b0, 2, 0, 32, 2, 1, 32'h3C3C_1234);

    // R8: early opening edge after 100 bits; partial frame dropped, restart
    scenario("R8", 1'b0, 1'b0, 1'b0, 1'b0, 2, 100, 0, 2, 2, 32'h0BAD_F00D);
    scenario("R8", 1'b1, 1'b1, 1'b1, 1'b1, 2, 100, 0, 2, 2, 32'h1357_9BDF);

    // R9 R10: two streams without reset; lock lost after first, regained cleanly
    do_reset(1'b0, 1'b0, 1'b0);
    g_req = "R10";
    vcnt = 0; mcnt = 0; mon_en = 1;
    run_stream(1'b0, 1'b0, 1'b0, 2, 0, 0, 32'hCAFE_0001);
    run_stream(1'b1, 1'b0, 1'b0, 2, 0, 0, 32'hCAFE_0002);
    chk(vcnt == 4, "R10", "frame_valid count over two streams", 256'(vcnt), 256'(4));
    chk(mcnt == 2, "R9", "misalign count over two streams", 256'(mcnt), 256'(2));
    mon_en = 0;

    // R9: no frame_valid while unlocked and idle
    vcnt = 0;
    repeat (600) @(negedge bclk);
    chk(vcnt == 0, "R9", "no output while unlocked", 256'(vcnt), '0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule